// File: doc/BRIEF.md
# Bus-Master DMA Channel Status and Descriptor Pointer Registers

This block holds the software-visible state for one channel of a bus-master disk DMA engine. It has a byte-wide status register and a 32-bit descriptor table pointer, both reached through one simple register port. A select input picks the register. Writes take effect on the clock edge. Reads are combinational and return the selected register, zero-extended where it is narrower than the port.

The status byte mixes several kinds of field:
- Three event flags are set by hardware and cleared by writing one: descriptor-interrupt done, bus abort error, and device interrupt.
- Two per-drive DMA-capable flags are plain storage for software.
- Two reserved bits always read zero.
- One read-only activity flag follows the engine's start control and its end-of-table completions.

The device interrupt line is asynchronous, so it passes through a synchronizer before its rising edge is detected. The data mover is outside this block. It only delivers pulses: descriptor done (qualified by end-of-table and interrupt-request flags), start-bit writes, and bus aborts.

Top module: `bmdma_status_regs`

## Requirements
- R1: After reset the status byte (csr_sel=0) reads 00h.
- R2: Bit 7 sets in the cycle after a desc_done pulse with desc_irq=1. A status write with csr_wdata[7]=1 clears it. A write with csr_wdata[7]=0 leaves it unchanged. desc_done with desc_irq=0 does not set it.
- R3: Status bits 4 and 3 always read 0, even after a write of ones to them.
- R4: Status bits 6:5 take csr_wdata[6:5] on every status write. Descriptor, abort, start and interrupt events never change them.
- R5: Bit 1 sets in the cycle after a bus_abort pulse. A status write with csr_wdata[1]=1 clears it.
- R6: Bit 2 sets on a rising edge of dev_irq. The flag is visible by the third clock edge after the line rises. A status write with csr_wdata[2]=1 clears it. While the line stays high after such a clear, the flag stays 0 until the line falls and rises again.
- R7: Bit 0 becomes start_val in the cycle after a start_wr pulse. A start write takes priority over a same-cycle end-of-table completion.
- R8: A desc_done pulse with desc_eot=1 clears bit 0. A desc_done pulse with desc_eot=0 leaves it unchanged. With bit 0 already 0, a completion leaves it 0.
- R9: When a hardware set event and a write-one clear hit the same flag in one cycle, the flag ends up 1.
- R10: With csr_sel=1, a write stores csr_wdata[31:2] in the pointer. A read returns those bits with bits 1:0 as 0. Pointer writes leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 1 | Register select: 0 status byte, 1 descriptor pointer |
| csr_wdata | input | 32 | Write data; status uses bits 7:0 |
| csr_rdata | output | 32 | Read data of the selected register |
| start_wr | input | 1 | Engine start-bit write strobe |
| start_val | input | 1 | Value written to the start bit |
| desc_done | input | 1 | Descriptor completed pulse |
| desc_eot | input | 1 | Completed descriptor was marked end-of-table |
| desc_irq | input | 1 | Completed descriptor requested an interrupt |
| dev_irq | input | 1 | Asynchronous device interrupt line |
| bus_abort | input | 1 | Bus transfer ended in target or master abort |

## Verification
The interrupt line is driven through three patterns:
- A first rising edge, which shows that the flag is edge-captured through the synchronizer.
- A clear while the line is held high, which separates edge capture from level capture.
- A fall followed by a new rise, which shows that capture re-arms.

Descriptor completions are sent with and without the end-of-table flag, both while active and while idle. Start writes are sent alone and together with an end-of-table completion, which pins down their relative priority. Write-one-to-clear writes are tried with zero data and with a same-cycle set event, so that clearing is told apart from holding and the set-over-clear priority is observed.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int STAT_W   = 8;
    localparam int N_W1C    = 3;

    localparam int POS_ACT  = 0;
    localparam int POS_ERR  = 1;
    localparam int POS_DIRQ = 2;
    localparam int POS_CAP0 = 5;
    localparam int POS_CAP1 = 6;
    localparam int POS_DONE = 7;

    // index of each write-one-to-clear flag in the flag vector
    localparam int W1C_ERR  = 0;
    localparam int W1C_DIRQ = 1;
    localparam int W1C_DONE = 2;

    typedef struct packed {
        logic [1:0] cap;
        logic       active;
    } ctl_state_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input ctl_state_t        st,
        input logic [N_W1C-1:0] flags
    );
        logic [STAT_W-1:0] b;
        b           = '0;
        b[POS_ACT]  = st.active;
        b[POS_ERR]  = flags[W1C_ERR];
        b[POS_DIRQ] = flags[W1C_DIRQ];
        b[POS_CAP0] = st.cap[0];
        b[POS_CAP1] = st.cap[1];
        b[POS_DONE] = flags[W1C_DONE];
        return b;
    endfunction

endpackage

// File: rtl/bmdma_w1c_flag.sv
module bmdma_w1c_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic sw_clr,
    output logic flag
);

    logic flag_d, flag_q;

    // a hardware set outranks a software clear in the same cycle
    always_comb begin
        flag_d = flag_q;
        if (sw_clr)  flag_d = 1'b0;
        if (set_evt) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

endmodule

// File: rtl/bmdma_edge_sync.sv
module bmdma_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], async_in};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/bmdma_dtp_reg.sv
module bmdma_dtp_reg #(
    parameter int AW    = 32,
    parameter int ALIGN = 2
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] rdata
);

    localparam int PW = AW - ALIGN;

    logic [PW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en) ptr_d = wdata[AW-1:ALIGN];
    end

    // no reset: contents are undefined until software loads them
    always_ff @(posedge clk) begin
        ptr_q <= ptr_d;
    end

    assign rdata = {ptr_q, {ALIGN{1'b0}}};

endmodule

// File: rtl/bmdma_status_regs.sv
module bmdma_status_regs
    import bmdma_pkg::*;
#(
    parameter int AW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_wr,
    input  logic          csr_sel,
    input  logic [AW-1:0] csr_wdata,
    output logic [AW-1:0] csr_rdata,
    input  logic          start_wr,
    input  logic          start_val,
    input  logic          desc_done,
    input  logic          desc_eot,
    input  logic          desc_irq,
    input  logic          dev_irq,
    input  logic          bus_abort
);

    localparam int PAD_W = AW - STAT_W;

    logic              stat_wr;
    logic              ptr_wr;
    logic              irq_rise;
    logic [N_W1C-1:0]  w1c_set;
    logic [N_W1C-1:0]  w1c_clr;
    logic [N_W1C-1:0]  w1c_flag;
    logic [AW-1:0]     ptr_rdata;
    logic [STAT_W-1:0] status_byte;
    ctl_state_t        st_d, st_q;

    assign stat_wr = csr_wr & ~csr_sel;
    assign ptr_wr  = csr_wr &  csr_sel;

    bmdma_edge_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (dev_irq),
        .rise     (irq_rise)
    );

    always_comb begin
        w1c_set                 = '0;
        w1c_set[W1C_ERR]        = bus_abort;
        w1c_set[W1C_DIRQ]       = irq_rise;
        w1c_set[W1C_DONE]       = desc_done & desc_irq;
        w1c_clr                 = '0;
        w1c_clr[W1C_ERR]        = stat_wr & csr_wdata[POS_ERR];
        w1c_clr[W1C_DIRQ]       = stat_wr & csr_wdata[POS_DIRQ];
        w1c_clr[W1C_DONE]       = stat_wr & csr_wdata[POS_DONE];
    end

    for (genvar i = 0; i < N_W1C; i++) begin : g_w1c
        bmdma_w1c_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (w1c_set[i]),
            .sw_clr  (w1c_clr[i]),
            .flag    (w1c_flag[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (stat_wr) st_d.cap = {csr_wdata[POS_CAP1], csr_wdata[POS_CAP0]};
        if (desc_done && desc_eot) st_d.active = 1'b0;
        if (start_wr) st_d.active = start_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bmdma_dtp_reg #(.AW(AW), .ALIGN(2)) u_dtp (
        .clk   (clk),
        .wr_en (ptr_wr),
        .wdata (csr_wdata),
        .rdata (ptr_rdata)
    );

    assign status_byte = pack_status(st_q, w1c_flag);
    assign csr_rdata   = csr_sel ? ptr_rdata : {{PAD_W{1'b0}}, status_byte};

endmodule

// File: rtl/bmdma_status_chk.sv
module bmdma_status_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          csr_wr,
    input logic          csr_sel,
    input logic [AW-1:0] csr_wdata,
    input logic          start_wr,
    input logic          start_val,
    input logic          desc_done,
    input logic          desc_eot,
    input logic          desc_irq,
    input logic          bus_abort,
    input logic [7:0]    status_byte
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[4:3] == 2'b00); // R3

    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done && desc_irq |=> status_byte[7]); // R2

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_wr && !csr_sel) |=> $stable(status_byte[6:5])); // R4

    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_abort |=> status_byte[1]); // R5

    AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr && !csr_sel && csr_wdata[1] && !bus_abort |=> !status_byte[1]); // R5

    AST_ACT_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> status_byte[0] == $past(start_val)); // R7

    AST_ACT_EOT: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done && desc_eot && !start_wr |=> !status_byte[0]); // R8

endmodule

bind bmdma_status_regs bmdma_status_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_wr      (csr_wr),
    .csr_sel     (csr_sel),
    .csr_wdata   (csr_wdata),
    .start_wr    (start_wr),
    .start_val   (start_val),
    .desc_done   (desc_done),
    .desc_eot    (desc_eot),
    .desc_irq    (desc_irq),
    .bus_abort   (bus_abort),
    .status_byte (status_byte)
);

// File: tb/tb_bmdma_status_regs.sv
`timescale 1ns/1ps
module tb_bmdma_status_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic        csr_sel = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        start_wr = 1'b0;
    logic        start_val = 1'b0;
    logic        desc_done = 1'b0;
    logic        desc_eot = 1'b0;
    logic        desc_irq = 1'b0;
    logic        dev_irq = 1'b0;
    logic        bus_abort = 1'b0;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    bmdma_status_regs dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .start_wr  (start_wr),
        .start_val (start_val),
        .desc_done (desc_done),
        .desc_eot  (desc_eot),
        .desc_irq  (desc_irq),
        .dev_irq   (dev_irq),
        .bus_abort (bus_abort)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        csr_sel = sel;
        #0.5;
        v = csr_rdata;
        csr_sel = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_sel = sel; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_sel = 1'b0; csr_wdata = '0;
    endtask

    task automatic pulse_desc(input logic eot, input logic irq);
        @(negedge clk);
        desc_done = 1'b1; desc_eot = eot; desc_irq = irq;
        @(negedge clk);
        desc_done = 1'b0; desc_eot = 1'b0; desc_irq = 1'b0;
    endtask

    task automatic pulse_start(input logic v);
        @(negedge clk);
        start_wr = 1'b1; start_val = v;
        @(negedge clk);
        start_wr = 1'b0; start_val = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); chk("R1 status after reset", v, 32'h00);
    endtask

    task automatic t_cap();
        logic [31:0] v;
        wr(1'b0, 32'h0000_0078);
        rd(1'b0, v); chk("R3 reserved masked, R4 caps written", v, 32'h60);
        pulse_desc(1'b1, 1'b0);
        pulse_start(1'b0);
        rd(1'b0, v); chk("R4 caps unchanged by events", v, 32'h60);
        wr(1'b0, 32'h0000_0020);
        rd(1'b0, v); chk("R4 cap1 cleared cap0 kept", v, 32'h20);
        wr(1'b0, 32'h0000_0000);
    endtask

    task automatic t_done();
        logic [31:0] v;
        pulse_desc(1'b0, 1'b0);
        rd(1'b0, v); chk("R2 no set without irq request", v, 32'h00);
        pulse_desc(1'b0, 1'b1);
        rd(1'b0, v); chk("R2 set on irq descriptor", v, 32'h80);
        wr(1'b0, 32'h0000_0000);
        rd(1'b0, v); chk("R2 write zero keeps flag", v, 32'h80);
        wr(1'b0, 32'h0000_0080);
        rd(1'b0, v); chk("R2 write one clears flag", v, 32'h00);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        @(negedge clk); bus_abort = 1'b1;
        @(negedge clk); bus_abort = 1'b0;
        rd(1'b0, v); chk("R5 abort sets error", v, 32'h02);
        wr(1'b0, 32'h0000_0002);
        rd(1'b0, v); chk("R5 write one clears error", v, 32'h00);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk); dev_irq = 1'b1;
        repeat (3) @(negedge clk);
        rd(1'b0, v); chk("R6 edge captured", v, 32'h04);
        wr(1'b0, 32'h0000_0004);
        repeat (4) @(negedge clk);
        rd(1'b0, v); chk("R6 stays clear while line high", v, 32'h00);
        dev_irq = 1'b0;
        repeat (4) @(negedge clk);
        dev_irq = 1'b1;
        repeat (4) @(negedge clk);
        rd(1'b0, v); chk("R6 new rising edge re-sets", v, 32'h04);
        dev_irq = 1'b0;
        wr(1'b0, 32'h0000_0004);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_active();
        logic [31:0] v;
        pulse_start(1'b1);
        rd(1'b0, v); chk("R7 start one sets active", v, 32'h01);
        pulse_desc(1'b0, 1'b0);
        rd(1'b0, v); chk("R8 non-eot completion keeps active", v, 32'h01);
        pulse_desc(1'b1, 1'b0);
        rd(1'b0, v); chk("R8 eot completion clears active", v, 32'h00);
        pulse_desc(1'b1, 1'b0);
        rd(1'b0, v); chk("R8 completion while idle stays idle", v, 32'h00);
        pulse_start(1'b1);
        pulse_start(1'b0);
        rd(1'b0, v); chk("R7 start zero clears active", v, 32'h00);
        @(negedge clk);
        start_wr = 1'b1; start_val = 1'b1; desc_done = 1'b1; desc_eot = 1'b1;
        @(negedge clk);
        start_wr = 1'b0; start_val = 1'b0; desc_done = 1'b0; desc_eot = 1'b0;
        rd(1'b0, v); chk("R7 start outranks eot completion", v, 32'h01);
        pulse_start(1'b0);
    endtask

    task automatic t_setwins();
        logic [31:0] v;
        @(negedge clk);
        desc_done = 1'b1; desc_irq = 1'b1; bus_abort = 1'b1;
        csr_wr = 1'b1; csr_wdata = 32'h0000_0082;
        @(negedge clk);
        desc_done = 1'b0; desc_irq = 1'b0; bus_abort = 1'b0;
        csr_wr = 1'b0; csr_wdata = '0;
        rd(1'b0, v); chk("R9 set beats same-cycle clear", v, 32'h82);
        wr(1'b0, 32'h0000_0082);
        rd(1'b0, v); chk("R9 flags clear afterwards", v, 32'h00);
    endtask

    task automatic t_ptr();
        logic [31:0] v;
        wr(1'b0, 32'h0000_0040);
        wr(1'b1, 32'hDEAD_BEEF);
        rd(1'b1, v); chk("R10 pointer low bits read zero", v, 32'hDEAD_BEEC);
        rd(1'b0, v); chk("R10 pointer write leaves status", v, 32'h40);
        wr(1'b1, 32'h1234_5678);
        rd(1'b1, v); chk("R10 pointer rewritten", v, 32'h1234_5678);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cap();
        t_done();
        t_abort();
        t_irq();
        t_active();
        t_setwins();
        t_ptr();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule